// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Threshold Flags

This block buffers 36-bit words from a write port to a read port. Each port runs on its own free-running clock. The two clocks may be unrelated, or they may be the same clock. The storage holds 64 words.

The write side reports two conditions, both active low:
- `full_n` is low when no location is free.
- `afull_n` is low when only a few locations are free.

The read side reports two more, also active low:
- `empty_n` is low when nothing is stored.
- `aempty_n` is low when only a few words are stored.

The pointer of each port crosses into the other clock domain in Gray code through a two-flop synchronizer. A flag therefore clears only after two edges of its own clock, but it sets on the very edge of the transfer that causes it. A transfer on either port takes effect when three things hold on the port's rising clock edge: select is low, enable is high, and the direction bit asks for that operation.

A single threshold drives both "almost" flags. It is captured from a two-bit select while reset is held low, so the value present at reset release is the one kept. Reset is active low and synchronous to each clock. It must be held for at least four edges of each clock.

Top module: `async_flag_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, and up to 64 words can be held at once.
- R2: `rd_data` takes the oldest stored word on the read-clock edge that accepts a read, and holds its value on every other edge.
- R3: A write is accepted only with `wr_cs_n`=0, `wr_en`=1 and `wr_dir`=1. A read is accepted only with `rd_cs_n`=0, `rd_en`=1 and `rd_dir`=0. Any other combination leaves the contents and `rd_data` unchanged.
- R4: After 64 stored words, `full_n` is low right after the write edge that filled the last location. Writes attempted while `full_n` is low are dropped.
- R5: Reads attempted while `empty_n` is low are dropped, and `rd_data` keeps its value.
- R6: While reset is low, after a clock edge: `full_n`=0, `afull_n`=1, `empty_n`=0, `aempty_n`=0 and `rd_data`=0.
- R7: `full_n` stays low on the first write-clock edge after reset release and goes high on the second.
- R8: After a write into an empty FIFO, `empty_n` goes high on the second read-clock edge after the write edge. It goes low right after the read edge that removes the last word.
- R9: `aempty_n` is low when the stored count seen by the read side is less than or equal to the threshold X.
- R10: `afull_n` is low when the free count seen by the write side is less than or equal to X.
- R11: `ofs_sel` is captured while reset is low, and the value at release selects X. The codes are 00→8, 01→16, 10→4 and 11→0. Later changes of `ofs_sel` have no effect.
- R12: From a full state, `full_n` goes high on the second write-clock edge after the read edge that frees a location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| ofs_sel | input | 2 | Threshold select, captured during reset |
| wr_cs_n | input | 1 | Write-port select, active low |
| wr_en | input | 1 | Write-port enable |
| wr_dir | input | 1 | Write-port direction, 1 = write |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when full |
| afull_n | output | 1 | Low when free count ≤ X |
| rd_cs_n | input | 1 | Read-port select, active low |
| rd_en | input | 1 | Read-port enable |
| rd_dir | input | 1 | Read-port direction, 0 = read |
| rd_data | output | 36 | Registered read word |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when stored count ≤ X |

## Verification
A corrupted pointer or synchronizer stage shows up at the ports in two ways:
- A wrong word, or a repeated word, appears on `rd_data` on the edge after a read. The in-order scoreboard catches this.
- A flag changes one edge early or one edge late. The bench samples every flag transition at the exact edge count the requirements give.

A wrong captured threshold shifts the `afull_n` and `aempty_n` boundaries by whole words, and each select code is tested at its own boundary. A write that should have been dropped becomes visible as soon as the FIFO is drained: `empty_n` stays high afterwards.

// File: rtl/fifo_pkg.sv
// Shared helpers for the dual-clock FIFO: threshold table for the almost flags.
// Assumes the select code is two bits wide.
package fifo_pkg;

    localparam int unsigned OFS_CODE00 = 8;
    localparam int unsigned OFS_CODE01 = 16;
    localparam int unsigned OFS_CODE10 = 4;
    localparam int unsigned OFS_CODE11 = 0;

    // Map a threshold select code to its word count.
    function automatic int unsigned pick_offset(input logic [1:0] code);
        case (code)
            2'b00:   return OFS_CODE00;
            2'b01:   return OFS_CODE01;
            2'b10:   return OFS_CODE10;
            default: return OFS_CODE11;
        endcase
    endfunction

endpackage

// File: rtl/gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer, followed by Gray-to-binary decode.
// Assumes the source changes by at most one bit per source-clock edge.
module gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Capture the foreign pointer through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Each binary bit is the XOR of all Gray bits at or above it.
    for (genvar i = 0; i < W; i++) begin : g_decode
        assign bin_out[i] = ^stage2[W-1:i];
    end
endmodule

// File: rtl/fifo_store.sv
// Dual-port storage: one write port, one registered read port on separate clocks.
// Assumes the control logic never writes the location being read in the same window.
module fifo_store #(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the accepted word.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Load the output register on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/wr_ctrl.sv
// Write-side control: write pointer, Gray copy, full and almost-full flags.
// Assumes rd_bin_s is the read pointer already synchronized to this clock.
module wr_ctrl
    import fifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  ofs_sel,
    input  logic        push_req,
    input  logic [AW:0] rd_bin_s,
    output logic        push,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray,
    output logic        full_n,
    output logic        afull_n
);
    localparam int PW = AW + 1;
    localparam logic [AW:0] DEPTH = PW'(1 << AW);

    logic [AW:0] ofs;
    logic [1:0]  ready;
    logic [AW:0] free_cnt;
    logic [AW:0] wptr_inc;

    // Hold the threshold code while reset is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) ofs <= PW'(pick_offset(ofs_sel));
    end

    // Two-edge start-up delay before full_n may rise.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 2'b00;
        else        ready <= {ready[0], 1'b1};
    end

    assign wptr_inc = wptr + 1'b1;

    // Advance the write pointer and its Gray copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (push) begin
            wptr  <= wptr_inc;
            wgray <= wptr_inc ^ (wptr_inc >> 1);
        end
    end

    assign free_cnt = DEPTH - (wptr - rd_bin_s);
    assign full_n   = ready[1] & (free_cnt != '0);
    assign afull_n  = ~ready[1] | (free_cnt > ofs);
    assign push     = push_req & full_n;
endmodule

// File: rtl/rd_ctrl.sv
// Read-side control: read pointer, Gray copy, empty and almost-empty flags.
// Assumes wr_bin_s is the write pointer already synchronized to this clock.
module rd_ctrl
    import fifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  ofs_sel,
    input  logic        pop_req,
    input  logic [AW:0] wr_bin_s,
    output logic        pop,
    output logic [AW:0] rptr,
    output logic [AW:0] rgray,
    output logic        empty_n,
    output logic        aempty_n
);
    localparam int PW = AW + 1;

    logic [AW:0] ofs;
    logic [AW:0] used_cnt;
    logic [AW:0] rptr_inc;

    // Hold the threshold code while reset is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) ofs <= PW'(pick_offset(ofs_sel));
    end

    assign rptr_inc = rptr + 1'b1;

    // Advance the read pointer and its Gray copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rptr  <= rptr_inc;
            rgray <= rptr_inc ^ (rptr_inc >> 1);
        end
    end

    assign used_cnt = wr_bin_s - rptr;
    assign empty_n  = (used_cnt != '0);
    assign aempty_n = (used_cnt > ofs);
    assign pop      = pop_req & empty_n;
endmodule

// File: rtl/async_flag_fifo.sv
// Dual-clock FIFO top: storage, both control sides and the two pointer crossings.
// Assumes reset is held low for at least four edges of each clock.
module async_flag_fifo #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_cs_n,
    input  logic              wr_en,
    input  logic              wr_dir,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_cs_n,
    input  logic              rd_en,
    input  logic              rd_dir,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = ADDR_W + 1;

    logic          push, pop;
    logic [PW-1:0] wptr, wgray, rptr, rgray;
    logic [PW-1:0] wptr_in_rd, rptr_in_wr;

    wr_ctrl #(.AW(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .push_req(!wr_cs_n && wr_en && wr_dir),
        .rd_bin_s(rptr_in_wr), .push(push), .wptr(wptr), .wgray(wgray),
        .full_n(full_n), .afull_n(afull_n)
    );

    rd_ctrl #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .pop_req(!rd_cs_n && rd_en && !rd_dir),
        .wr_bin_s(wptr_in_rd), .pop(pop), .rptr(rptr), .rgray(rgray),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_in_rd)
    );

    gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_in_wr)
    );

    fifo_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(push), .waddr(wptr[ADDR_W-1:0]), .wdata(wr_data),
        .rclk(rd_clk), .rst_n(rst_n), .re(pop), .raddr(rptr[ADDR_W-1:0]),
        .rdata(rd_data)
    );
endmodule

// File: rtl/fifo_flag_chk.sv
// Port-level property checker for async_flag_fifo, attached by bind below.
module fifo_flag_chk #(
    parameter int DW = 36
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          rd_cs_n,
    input logic          rd_en,
    input logic          rd_dir,
    input logic [DW-1:0] rd_data,
    input logic          empty_n,
    input logic          aempty_n
);
    // R6: write-side flags while reset is applied
    assert_reset_wr_R6: assert property (@(posedge wr_clk)
        !rst_n |=> (!full_n && afull_n));

    // R6: read-side flags while reset is applied
    assert_reset_rd_R6: assert property (@(posedge rd_clk)
        !rst_n |=> (!empty_n && !aempty_n));

    // R9: an empty FIFO is also almost empty
    assert_empty_implies_low_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R10: entering full also means almost full
    assert_full_implies_afull_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(full_n) |-> !afull_n);

    // R2: output word holds when no read is accepted
    assert_hold_rd_data_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(!rd_cs_n && rd_en && !rd_dir && empty_n) |=> $stable(rd_data));

    // R7: full_n can only rise once reset has been gone for two edges
    assert_full_rise_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(full_n) |-> $past(rst_n, 2));
endmodule

bind async_flag_fifo fifo_flag_chk #(.DW(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .full_n(full_n), .afull_n(afull_n),
    .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_dir(rd_dir), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
);

// File: tb/tb_async_flag_fifo.sv
module tb_async_flag_fifo;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ofs_sel;
    logic        wr_cs_n, wr_en, wr_dir;
    logic [35:0] wr_data;
    logic        full_n, afull_n;
    logic        rd_cs_n, rd_en, rd_dir;
    logic [35:0] rd_data;
    logic        empty_n, aempty_n;

    int checks = 0;
    int errors = 0;
    logic [35:0] exp_q [$];
    logic        rd_expect = 1'b0;
    logic [35:0] held;

    always #10 wr_clk = ~wr_clk;
    always #10 rd_clk = ~rd_clk;

    async_flag_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_dir(wr_dir), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_dir(rd_dir), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge wr_clk);
        @(negedge wr_clk);
    endtask

    task automatic wr(input logic [35:0] d, input bit accept);
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_dir = 1'b1; wr_data = d;
        if (accept) exp_q.push_back(d);
        tick();
        wr_cs_n = 1'b1; wr_en = 1'b0; wr_dir = 1'b0;
    endtask

    task automatic rd(input bit accept);
        rd_cs_n = 1'b0; rd_en = 1'b1; rd_dir = 1'b0; rd_expect = accept;
        tick();
        rd_cs_n = 1'b1; rd_en = 1'b0; rd_dir = 1'b1; rd_expect = 1'b0;
    endtask

    task automatic rw(input logic [35:0] d);
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_dir = 1'b1; wr_data = d;
        rd_cs_n = 1'b0; rd_en = 1'b1; rd_dir = 1'b0; rd_expect = 1'b1;
        exp_q.push_back(d);
        tick();
        wr_cs_n = 1'b1; wr_en = 1'b0; wr_dir = 1'b0;
        rd_cs_n = 1'b1; rd_en = 1'b0; rd_dir = 1'b1; rd_expect = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] sel, input logic [1:0] sel_after);
        rst_n = 1'b0; ofs_sel = sel;
        repeat (5) tick();
        exp_q.delete();
        chk("R6 full_n", 36'(full_n), 36'd0);
        chk("R6 afull_n", 36'(afull_n), 36'd1);
        chk("R6 empty_n", 36'(empty_n), 36'd0);
        chk("R6 aempty_n", 36'(aempty_n), 36'd0);
        chk("R6 rd_data", rd_data, 36'd0);
        rst_n = 1'b1; ofs_sel = sel_after;
        tick();
        chk("R7 full_n first edge", 36'(full_n), 36'd0);
        tick();
        chk("R7 full_n second edge", 36'(full_n), 36'd1);
    endtask

    function automatic logic [35:0] pat(input int i);
        return {4'hA, 32'(i * 32'h9E37 + 5)};
    endfunction

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor: compares each accepted read one step after its edge (R1, R2).
    always @(posedge rd_clk) begin
        if (rd_expect) begin
            #1;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 actual=%h expected=<none>", rd_data);
            end else begin
                logic [35:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL R1/R2 actual=%h expected=%h", rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge wr_clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; ofs_sel = 2'b00;
        wr_cs_n = 1'b1; wr_en = 1'b0; wr_dir = 1'b0; wr_data = '0;
        rd_cs_n = 1'b1; rd_en = 1'b0; rd_dir = 1'b1;
        @(negedge wr_clk);

        // Basic flow and empty timing, X = 8
        do_reset(2'b00, 2'b00);
        wr(pat(0), 1);
        chk("R8 empty_n at write edge", 36'(empty_n), 36'd0);
        tick();
        chk("R8 empty_n one edge later", 36'(empty_n), 36'd0);
        tick();
        chk("R8 empty_n second edge", 36'(empty_n), 36'd1);
        chk("R9 aempty_n count 1", 36'(aempty_n), 36'd0);
        rd(1);
        chk("R8 empty_n after last read", 36'(empty_n), 36'd0);
        held = rd_data;
        rd(0);
        chk("R5 read while empty", rd_data, held);

        // R3: unqualified writes ignored
        wr_cs_n = 1'b1; wr_en = 1'b1; wr_dir = 1'b1; tick();
        wr_cs_n = 1'b0; wr_en = 1'b0; wr_dir = 1'b1; tick();
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_dir = 1'b0; tick();
        wr_cs_n = 1'b1; wr_en = 1'b0; wr_dir = 1'b0;
        repeat (3) tick();
        chk("R3 write ignored", 36'(empty_n), 36'd0);
        wr(pat(1), 1);
        wr(pat(2), 1);
        repeat (2) tick();
        // R3: unqualified reads ignored
        rd_cs_n = 1'b1; rd_en = 1'b1; rd_dir = 1'b0; tick();
        rd_cs_n = 1'b0; rd_en = 1'b0; rd_dir = 1'b0; tick();
        rd_cs_n = 1'b0; rd_en = 1'b1; rd_dir = 1'b1; tick();
        rd_cs_n = 1'b1; rd_en = 1'b0; rd_dir = 1'b1;
        chk("R3 read ignored", rd_data, held);
        rd(1);
        rd(1);

        // Fill to full: R10, R4
        for (int i = 0; i < 64; i++) begin
            wr(pat(100 + i), 1);
            if (i == 54) chk("R10 afull_n free 9", 36'(afull_n), 36'd1);
            if (i == 55) chk("R10 afull_n free 8", 36'(afull_n), 36'd0);
            if (i == 62) chk("R4 full_n free 1", 36'(full_n), 36'd1);
            if (i == 63) chk("R4 full_n free 0", 36'(full_n), 36'd0);
        end
        wr(36'hF_DEAD_BEEF, 0);
        repeat (2) tick();
        chk("R9 aempty_n count 64", 36'(aempty_n), 36'd1);
        rd(1);
        chk("R12 full_n at read edge", 36'(full_n), 36'd0);
        tick();
        chk("R12 full_n one edge later", 36'(full_n), 36'd0);
        tick();
        chk("R12 full_n second edge", 36'(full_n), 36'd1);
        repeat (54) rd(1);
        chk("R9 aempty_n count 9", 36'(aempty_n), 36'd1);
        rd(1);
        chk("R9 aempty_n count 8", 36'(aempty_n), 36'd0);
        repeat (8) rd(1);
        repeat (3) tick();
        chk("R4 dropped write not stored", 36'(empty_n), 36'd0);
        chk("R1 queue drained", 36'(exp_q.size()), 36'd0);

        // Streaming with simultaneous read and write: R1
        for (int i = 0; i < 10; i++) wr(pat(300 + i), 1);
        repeat (2) tick();
        for (int i = 0; i < 40; i++) rw(pat(400 + i));
        repeat (10) rd(1);
        repeat (3) tick();
        chk("R1 stream drained", 36'(exp_q.size()), 36'd0);
        chk("R1 stream empty", 36'(empty_n), 36'd0);

        // R11: code 01 -> 16, later pin change ignored
        do_reset(2'b01, 2'b11);
        for (int i = 0; i < 48; i++) begin
            wr(pat(500 + i), 1);
            if (i == 46) chk("R11 afull_n X16 free 17", 36'(afull_n), 36'd1);
            if (i == 47) chk("R11 afull_n X16 free 16", 36'(afull_n), 36'd0);
        end
        repeat (2) tick();
        repeat (31) rd(1);
        chk("R11 aempty_n X16 count 17", 36'(aempty_n), 36'd1);
        rd(1);
        chk("R11 aempty_n X16 count 16", 36'(aempty_n), 36'd0);

        // R11: code 11 -> 0
        do_reset(2'b11, 2'b00);
        wr(pat(600), 1);
        repeat (2) tick();
        chk("R11 aempty_n X0 count 1", 36'(aempty_n), 36'd1);
        for (int i = 1; i < 63; i++) wr(pat(600 + i), 1);
        chk("R11 afull_n X0 free 1", 36'(afull_n), 36'd1);
        wr(pat(700), 1);
        chk("R11 afull_n X0 free 0", 36'(afull_n), 36'd0);

        // R11: code 10 -> 4
        do_reset(2'b10, 2'b00);
        for (int i = 0; i < 4; i++) wr(pat(800 + i), 1);
        repeat (2) tick();
        chk("R11 aempty_n X4 count 4", 36'(aempty_n), 36'd0);
        wr(pat(804), 1);
        repeat (2) tick();
        chk("R11 aempty_n X4 count 5", 36'(aempty_n), 36'd1);

        finish_up();
    end
endmodule